// File: doc/BRIEF.md
# Fixed-latency go/done sequencer

This block lets a datapath whose schedule takes a fixed number of cycles run behind a go/done handshake. While it is idle, a request on `go` starts a run. The run's first cycle is the cycle in which `go` is seen, so the datapath does useful work at once. An internal cycle counter then steps through the remaining cycles of the schedule and falls back to idle. From `go` and the counter the block decodes time-window enables for the datapath. A one-cycle pulse on `done` marks the idle cycle that follows a finished run.

A window that starts at cycle 0 and lasts longer than one cycle is built in two parts. The cycle-0 part is qualified by `go` while the counter is idle. The part from cycle 1 up to the window's end comes from the counter value. Both parts are brought out separately, together with their union, so that each can be seen on its own. When the schedule latency is one cycle, no counter is built. The enable then simply follows `go`, and `done` trails `go` by one cycle.

Top module: `sched_sequencer`

## Requirements
- R1: A synchronous active-low reset returns the block to idle. In the first cycle after reset is released, with `go` low, `win_first`, `win_rest`, `win_span` and `done` are all 0.
- R2: When `go` is high while the block is idle, `win_first` is 1 in that same cycle, and the run counts that cycle as its cycle 0.
- R3: With `LATENCY` > 1, `win_rest` is 1 exactly on cycles 1 to `WIN_END`-1 of a run, counted from the cycle 0 of R2. It is 0 on every other cycle, including cycle 0.
- R4: With `LATENCY` > 1, a run occupies exactly `LATENCY` cycles. `go` has no effect during cycles 1 to `LATENCY`-1: `win_first` stays 0 there, and the run still ends at its normal time.
- R5: `win_span` is the window covering cycles 0 to `WIN_END`-1 of a run. It is 1 when `win_first` or `win_rest` is 1, and 0 otherwise.
- R6: With `LATENCY` > 1, `done` is 1 for one cycle: the cycle `LATENCY` cycles after a run's cycle 0, when the block is idle again. `done` is 0 at all other times.
- R7: If `go` is held high without a break, a new run starts in the idle cycle right after each run ends. In that cycle `done` and `win_first` are both 1, so runs repeat every `LATENCY` cycles.
- R8: With `LATENCY` = 1, `win_first` and `win_span` equal `go` in every cycle, and `win_rest` is always 0.
- R9: With `LATENCY` = 1, `done` equals the value that `go` had in the previous cycle, and is 0 in the first cycle after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| go | input | 1 | Start request, accepted while idle |
| win_first | output | 1 | Enable for cycle 0 of a run |
| win_rest | output | 1 | Enable for cycles 1 to WIN_END-1 of a run |
| win_span | output | 1 | Enable for cycles 0 to WIN_END-1 of a run |
| done | output | 1 | One-cycle pulse in the idle cycle after a run |

## Verification
The bench builds two instances that share `go` and reset. The first uses `LATENCY` = 5 and `WIN_END` = 3. It exercises the counter's start, step and wrap paths, a rest window that closes before the run does, `go` arriving while busy, and back-to-back runs. The second uses `LATENCY` = 1, which exercises the counterless variant, where enables follow `go` and `done` is a one-cycle delayed copy of it. Both instances are driven by directed sequences and then by seeded random requests, including a reset during a run.

// File: rtl/seq_pkg.sv
// Package: shared helpers for the fixed-latency sequencer.
// Assumes a schedule latency of at least one cycle.
package seq_pkg;
    // Bits needed to hold the value LATENCY+1.
    function automatic int cnt_width(input int lat);
        return $clog2(lat + 2);
    endfunction
endpackage

// File: rtl/seq_counter.sv
// Module: seq_counter
// The run counter for schedules longer than one cycle. It sits at 0 while
// idle and loads 1 when go is seen in that state. It then climbs by one each
// cycle and drops back to 0 after reaching LATENCY-1. It is written on every
// clock, and go is ignored while the count is non-zero.
// Assumes LATENCY >= 2.
module seq_counter
    import seq_pkg::*;
#(
    parameter int LATENCY = 5,
    parameter int CW      = cnt_width(LATENCY)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          go,
    output logic [CW-1:0] cnt
);
    localparam logic [CW-1:0] CNT_ONE  = CW'(1);
    localparam logic [CW-1:0] CNT_LAST = CW'(LATENCY - 1);

    // Start, step or wrap the counter on every clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (cnt == '0) begin
            cnt <= go ? CNT_ONE : '0;
        end else if (cnt == CNT_LAST) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + CNT_ONE;
        end
    end
endmodule

// File: rtl/seq_window.sv
// Module: seq_window
// Decodes the enables for the window [0, WIN_END) of a run. Cycle 0 comes
// from go while the counter is idle. Cycles 1 to WIN_END-1 come from the
// counter value. The union of the two is also given.
// Assumes 1 <= WIN_END <= LATENCY, and a count of 0 whenever the block is idle.
module seq_window #(
    parameter int CW      = 3,
    parameter int WIN_END = 3
) (
    input  logic          go,
    input  logic [CW-1:0] cnt,
    output logic          first,
    output logic          rest,
    output logic          span
);
    localparam logic [CW-1:0] END_V = CW'(WIN_END);

    // Cycle-0 enable: the request itself, taken only while idle.
    assign first = go && (cnt == '0);

    generate
        if (WIN_END > 1) begin : g_rest
            // Later cycles of the window, decoded from the count.
            assign rest = (cnt != '0) && (cnt < END_V);
        end else begin : g_no_rest
            // A window of one cycle has no counter-decoded part.
            assign rest = 1'b0;
        end
    endgenerate

    // Whole window: the cycle-0 part joined with the later part.
    assign span = first | rest;
endmodule

// File: rtl/seq_done_flag.sv
// Module: seq_done_flag
// Holds a registered copy of go that is written only while wr_en is high.
// done is the stored copy qualified by wr_en. The top drives wr_en with
// "counter idle" for multi-cycle schedules, and with a constant 1 when the
// latency is one cycle.
module seq_done_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_en,
    input  logic d,
    output logic done
);
    logic flag_q;

    // Capture go whenever a write is allowed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else if (wr_en) begin
            flag_q <= d;
        end
    end

    // Report completion only in a cycle where the flag may be written.
    assign done = flag_q & wr_en;
endmodule

// File: rtl/sched_sequencer.sv
// Module: sched_sequencer
// Top of the go/done sequencer. It wraps a schedule of LATENCY cycles and
// produces the cycle-0, later-cycle and whole-window enables for the window
// [0, WIN_END), plus a done pulse. For LATENCY == 1 no counter is built.
// Assumes 1 <= WIN_END <= LATENCY.
module sched_sequencer
    import seq_pkg::*;
#(
    parameter int LATENCY = 5,
    parameter int WIN_END = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic go,
    output logic win_first,
    output logic win_rest,
    output logic win_span,
    output logic done
);
    localparam int CW = cnt_width(LATENCY);

    logic [CW-1:0] cnt_q;
    logic          idle;
    logic          flag_we;

    generate
        if (LATENCY > 1) begin : g_multi
            // Multi-cycle schedule: a real counter, with the flag written only while idle.
            seq_counter #(
                .LATENCY(LATENCY),
                .CW     (CW)
            ) u_cnt (
                .clk  (clk),
                .rst_n(rst_n),
                .go   (go),
                .cnt  (cnt_q)
            );
            assign flag_we = idle;
        end else begin : g_single
            // One-cycle schedule: no counter, and the flag is written every cycle.
            assign cnt_q   = '0;
            assign flag_we = 1'b1;
        end
    endgenerate

    // The block is idle when the count is 0.
    assign idle = (cnt_q == '0);

    seq_window #(
        .CW     (CW),
        .WIN_END(WIN_END)
    ) u_win (
        .go   (go),
        .cnt  (cnt_q),
        .first(win_first),
        .rest (win_rest),
        .span (win_span)
    );

    seq_done_flag u_done (
        .clk  (clk),
        .rst_n(rst_n),
        .wr_en(flag_we),
        .d    (go),
        .done (done)
    );
endmodule

// File: rtl/sched_sequencer_chk.sv
// Module: sched_sequencer_chk
// Temporal checks on the sequencer, bound into every instance of the top.
module sched_sequencer_chk #(
    parameter int LATENCY = 5,
    parameter int CW      = 3
) (
    input logic          clk,
    input logic          rst_n,
    input logic          go,
    input logic [CW-1:0] cnt,
    input logic          win_first,
    input logic          win_rest,
    input logic          win_span,
    input logic          done
);
    generate
        if (LATENCY > 1) begin : g_multi
            // A cycle-0 enable is followed by counter value 1.
            assert_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
                win_first |=> (cnt == CW'(1)));
            // go during a run does not open cycle 0.
            assert_busy_ignore_R4: assert property (@(posedge clk) disable iff (!rst_n)
                (go && cnt != '0) |-> !win_first);
            // The counter steps by one inside a run.
            assert_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
                (cnt != '0 && cnt != CW'(LATENCY - 1)) |=> (cnt == $past(cnt) + CW'(1)));
            // The counter wraps to idle after the last cycle.
            assert_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
                (cnt == CW'(LATENCY - 1)) |=> (cnt == '0));
            // Cycle-0 and later-cycle enables never overlap.
            assert_rest_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
                !(win_first && win_rest));
            // A later-cycle enable is always preceded by a whole-window cycle.
            assert_span_prev_R5: assert property (@(posedge clk) disable iff (!rst_n)
                win_rest |-> $past(win_span));
            // done follows the last cycle of a run.
            assert_done_after_run_R6: assert property (@(posedge clk) disable iff (!rst_n)
                done |-> ($past(cnt) == CW'(LATENCY - 1)));
        end else begin : g_single
            // Without a counter, done trails go by one cycle.
            assert_done_delay_R9: assert property (@(posedge clk) disable iff (!rst_n)
                $past(rst_n) |-> (done == $past(go)));
            // Without a counter, there is no later-cycle window.
            assert_no_rest_R8: assert property (@(posedge clk) disable iff (!rst_n)
                !win_rest);
            // The whole window equals the request.
            assert_span_go_R8: assert property (@(posedge clk) disable iff (!rst_n)
                win_span == go);
            // The cycle-0 enable always lies inside the window.
            assert_first_in_span_R5: assert property (@(posedge clk) disable iff (!rst_n)
                win_first |-> win_span);
        end
    endgenerate
endmodule

bind sched_sequencer sched_sequencer_chk #(
    .LATENCY(LATENCY),
    .CW     (CW)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .go       (go),
    .cnt      (cnt_q),
    .win_first(win_first),
    .win_rest (win_rest),
    .win_span (win_span),
    .done     (done)
);

// File: tb/sim_sched_sequencer.sv
`timescale 1ns/1ps
module sim_sched_sequencer;
    localparam int LAT = 5;
    localparam int WE  = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic go = 1'b0;
    logic a_first, a_rest, a_span, a_done;
    logic b_first, b_rest, b_span, b_done;

    int checks = 0;
    int errors = 0;
    bit finished = 0;
    string done_tag = "R6";

    // Reference state: cycle of the current run (0 = idle), the run-start
    // memory behind done, and the previous go for the one-cycle instance.
    int  m_cyc = 0;
    bit  m_ended = 0;
    bit  m_go_prev = 0;

    always #4 clk = ~clk;

    sched_sequencer #(.LATENCY(LAT), .WIN_END(WE)) u0 (
        .clk(clk), .rst_n(rst_n), .go(go),
        .win_first(a_first), .win_rest(a_rest), .win_span(a_span), .done(a_done));

    sched_sequencer #(.LATENCY(1), .WIN_END(1)) u1 (
        .clk(clk), .rst_n(rst_n), .go(go),
        .win_first(b_first), .win_rest(b_rest), .win_span(b_span), .done(b_done));

    task automatic chk(input logic act, input logic exp, input string tag, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%b expected=%b at %0t", tag, what, act, exp, $time);
        end
    endtask

    function automatic bit exp_rest(input int c);
        return (c >= 1) && (c < WE);
    endfunction

    // Compare all outputs, then advance one clock and update the reference.
    task automatic step(input logic g);
        bit ef;
        bit er;
        go = g;
        #1;
        ef = g && (m_cyc == 0);
        er = exp_rest(m_cyc);
        chk(a_first, ef, (m_cyc == 0) ? "R2" : "R4", "u0.win_first");
        chk(a_rest, er, "R3", "u0.win_rest");
        chk(a_span, ef | er, "R5", "u0.win_span");
        chk(a_done, (m_cyc == 0) && m_ended, done_tag, "u0.done");
        chk(b_first, g, "R8", "u1.win_first");
        chk(b_span, g, "R8", "u1.win_span");
        chk(b_rest, 1'b0, "R8", "u1.win_rest");
        chk(b_done, m_go_prev, "R9", "u1.done");
        @(posedge clk);
        // A run ends when cycle LAT-1 is left; that is remembered for done.
        if (m_cyc == 0) begin
            m_ended = 0;
            m_cyc = g ? 1 : 0;
        end else if (m_cyc == LAT - 1) begin
            m_cyc = 0;
            m_ended = 1;
        end else begin
            m_cyc = m_cyc + 1;
        end
        m_go_prev = g;
        @(negedge clk);
    endtask

    task automatic do_reset(input int n);
        rst_n = 1'b0;
        go = 1'b0;
        repeat (n) @(posedge clk);
        m_cyc = 0;
        m_ended = 0;
        m_go_prev = 0;
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic finish_run;
        if (!finished) begin
            finished = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        void'($urandom(32'd4242));
        @(negedge clk);
        do_reset(3);

        // R1: idle state right after reset.
        #1;
        chk(a_first, 1'b0, "R1", "u0.win_first");
        chk(a_rest, 1'b0, "R1", "u0.win_rest");
        chk(a_span, 1'b0, "R1", "u0.win_span");
        chk(a_done, 1'b0, "R1", "u0.done");
        chk(b_done, 1'b0, "R1", "u1.done");
        step(1'b0);

        // R2, R3, R6: a single request, then the run drains.
        done_tag = "R6";
        step(1'b1);
        for (int i = 0; i < LAT + 2; i++) step(1'b0);

        // R4: go is held high during a run; it must not restart the run.
        step(1'b1);
        step(1'b0);
        for (int i = 0; i < LAT - 2; i++) step(1'b1);
        step(1'b0);
        step(1'b0);

        // R7: go held continuously gives back-to-back runs.
        done_tag = "R7";
        for (int i = 0; i < 3 * LAT + 1; i++) step(1'b1);
        done_tag = "R6";
        for (int i = 0; i < LAT + 1; i++) step(1'b0);

        // R1: a reset during a run returns the block to idle.
        step(1'b1);
        step(1'b0);
        step(1'b0);
        do_reset(1);
        done_tag = "R1";
        step(1'b0);
        done_tag = "R6";
        step(1'b0);

        // Random requests against the reference, with about 30% density.
        for (int i = 0; i < 600; i++) step(($urandom % 10) < 3);
        for (int i = 0; i < LAT + 1; i++) step(1'b0);

        finish_run();
    end
endmodule